// File: doc/BRIEF.md
# Affine Loop-Nest Access Controller

This block drives the read or write port of one buffer from a static loop-nest description, with no handshake anywhere. A set of nested loop counters, up to six deep, steps through an iteration space. For each iteration, two affine generators produce values of the form offset plus the sum of stride times index. One value is the buffer address. The other is the clock cycle on which that access must happen. A free-running cycle counter is compared against the scheduled cycle, and the access enable is raised on exactly that cycle.

A flush pulse does three things: it captures the loop configuration, restarts the cycle counter at zero and rewinds every loop index. Two sets of strides are loaded, one for addresses and one for the schedule. After the access of the final iteration, the controller parks in a finished state until the next flush.

The control path has three named states. IDLE is entered from reset and left for RUN on flush. RUN loops to itself while accesses are pending, and a flush also restarts it in RUN. RUN moves to DONE on the enable of the final iteration. DONE moves back to RUN on flush.

Top module: `affine_loop_ctrl`

## Requirements
- R1: `cycle_count` increments by one every clock, modulo 2^TIME_W, in every state. It reads 0 in the cycle that follows a clock edge at which `flush` was high.
- R2: From any state, a flush captures the extents and strides from the configuration ports, resets all loop indices to 0 and enters RUN. Address and schedule then start from `cfg_addr_off` and `cfg_sched_off`.
- R3: Dimension 0 is the innermost loop. Dimension d occupies bits [d*EXT_W +: EXT_W] of `cfg_extent`. Its index runs from 0 to extent-1. When a dimension wraps, all lower indices return to 0 and the next higher index increments. An extent of 1 makes a dimension inactive. Every extent must be at least 1.
- R4: During iteration (i0..i5), `acc_addr` equals `cfg_addr_off` + Σ stride[d]·i[d], modulo 2^ADDR_W. Address stride d occupies bits [d*ADDR_W +: ADDR_W]. The value holds steady while the iteration waits for its cycle.
- R5: `acc_en` is high only in RUN, and only in a cycle where `cycle_count` equals `cfg_sched_off` + Σ sched_stride[d]·i[d] (modulo 2^TIME_W) for the pending iteration. Schedule stride d occupies bits [d*TIME_W +: TIME_W].
- R6: In the cycle after the enable of the last iteration, `done` goes high. It stays high, with `acc_en` low, until a flush.
- R7: While reset is held, `acc_en`, `done` and `cycle_count` are 0, and the state is IDLE. In IDLE, no enable is issued.
- R8: If consecutive schedule values differ by one, enables occur on back-to-back cycles and the address advances every cycle.
- R9: Changes on the configuration ports between flushes have no effect on the running loop nest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restart counter, capture configuration, rewind loop nest |
| cfg_extent | input | NDIM*EXT_W | Loop extent per dimension, dimension 0 in the low bits |
| cfg_addr_off | input | ADDR_W | Address offset |
| cfg_addr_stride | input | NDIM*ADDR_W | Address stride per dimension |
| cfg_sched_off | input | TIME_W | Schedule offset in cycles |
| cfg_sched_stride | input | NDIM*TIME_W | Schedule stride per dimension in cycles |
| cycle_count | output | TIME_W | Free-running cycle counter |
| acc_en | output | 1 | Access enable for the buffer |
| acc_addr | output | ADDR_W | Address for the pending access |
| done | output | 1 | Loop nest completed |

## Verification
The bench builds the block with NDIM=6, EXT_W=8, ADDR_W=16 and TIME_W=16. With six dimensions, a nest in which every extent is 2 visits all carry positions in 64 accesses, with dense back-to-back enables. A 16-bit address width lets an offset near the top of the range show modular wrap within a short run. Other cases cover a two-level nest with sparse timing, a three-level nest with unequal extents, a single-iteration nest and a flush in the middle of a run. Each case is checked against a loop model written in the bench.

// File: rtl/loop_ctrl_pkg.sv
package loop_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } lc_state_e;
endpackage

// File: rtl/loop_iter_domain.sv
module loop_iter_domain #(
    parameter int NDIM  = 6,
    parameter int EXT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    step,
    input  logic [NDIM*EXT_W-1:0]   extent,
    output logic [SEL_W-1:0]        sel,
    output logic                    last
);
    logic [EXT_W-1:0] idx_q [NDIM];
    logic [NDIM-1:0]  at_max;

    for (genvar g = 0; g < NDIM; g++) begin : g_max
        assign at_max[g] = (idx_q[g] == (extent[g*EXT_W +: EXT_W] - EXT_W'(1)));
    end

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int d = 0; d < NDIM; d++) begin
            if (!found && !at_max[d]) begin
                sel   = SEL_W'(d);
                found = 1'b1;
            end
        end
    end

    assign last = &at_max;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < NDIM; d++) idx_q[d] <= '0;
        end else if (load) begin
            for (int d = 0; d < NDIM; d++) idx_q[d] <= '0;
        end else if (step && !last) begin
            for (int d = 0; d < NDIM; d++) begin
                if (SEL_W'(d) == sel)     idx_q[d] <= idx_q[d] + EXT_W'(1);
                else if (SEL_W'(d) < sel) idx_q[d] <= '0;
            end
        end
    end

    // R3: carrying into a higher dimension clears the innermost index
    a_r3_inner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !load && sel != '0) |=> (idx_q[0] == '0));
endmodule

// File: rtl/affine_term_gen.sv
module affine_term_gen #(
    parameter int NDIM  = 6,
    parameter int EXT_W = 8,
    parameter int VAL_W = 16,
    parameter int SEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    step,
    input  logic [SEL_W-1:0]        sel,
    input  logic [VAL_W-1:0]        offset,
    input  logic [NDIM*VAL_W-1:0]   stride,
    input  logic [NDIM*EXT_W-1:0]   extent,
    output logic [VAL_W-1:0]        value
);
    localparam int PW = VAL_W + EXT_W;

    logic [PW-1:0]    span   [NDIM];
    logic [VAL_W-1:0] prefix [NDIM+1];
    logic [VAL_W-1:0] delta  [NDIM];
    logic [VAL_W-1:0] jump;
    logic [VAL_W-1:0] value_q;

    assign prefix[0] = '0;
    for (genvar g = 0; g < NDIM; g++) begin : g_delta
        assign span[g]     = PW'(stride[g*VAL_W +: VAL_W])
                           * PW'(extent[g*EXT_W +: EXT_W] - EXT_W'(1));
        assign prefix[g+1] = prefix[g] + span[g][VAL_W-1:0];
        assign delta[g]    = stride[g*VAL_W +: VAL_W] - prefix[g];
    end

    always_comb begin
        jump = '0;
        for (int d = 0; d < NDIM; d++) begin
            if (SEL_W'(d) == sel) jump = delta[d];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     value_q <= '0;
        else if (load)  value_q <= offset;
        else if (step)  value_q <= value_q + jump;
    end

    assign value = value_q;
endmodule

// File: rtl/affine_loop_ctrl.sv
module affine_loop_ctrl
    import loop_ctrl_pkg::*;
#(
    parameter int NDIM   = 6,
    parameter int EXT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int TIME_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [NDIM*EXT_W-1:0]    cfg_extent,
    input  logic [ADDR_W-1:0]        cfg_addr_off,
    input  logic [NDIM*ADDR_W-1:0]   cfg_addr_stride,
    input  logic [TIME_W-1:0]        cfg_sched_off,
    input  logic [NDIM*TIME_W-1:0]   cfg_sched_stride,
    output logic [TIME_W-1:0]        cycle_count,
    output logic                     acc_en,
    output logic [ADDR_W-1:0]        acc_addr,
    output logic                     done
);
    localparam int SEL_W = (NDIM > 1) ? $clog2(NDIM) : 1;

    lc_state_e                state_q, state_d;
    logic [TIME_W-1:0]        cycle_q;
    logic [NDIM*EXT_W-1:0]    ext_q;
    logic [NDIM*ADDR_W-1:0]   astr_q;
    logic [NDIM*TIME_W-1:0]   sstr_q;
    logic [SEL_W-1:0]         sel;
    logic                     last;
    logic                     step;
    logic [TIME_W-1:0]        sched_val;
    logic                     hit;

    // configuration capture and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cycle_q <= '0;
            ext_q   <= '0;
            astr_q  <= '0;
            sstr_q  <= '0;
        end else if (flush) begin
            cycle_q <= '0;
            ext_q   <= cfg_extent;
            astr_q  <= cfg_addr_stride;
            sstr_q  <= cfg_sched_stride;
        end else begin
            cycle_q <= cycle_q + TIME_W'(1);
        end
    end

    assign hit  = (cycle_q == sched_val);
    assign step = acc_en && !flush;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (flush) state_d = ST_RUN;
            ST_RUN: begin
                if (flush)            state_d = ST_RUN;
                else if (hit && last) state_d = ST_DONE;
            end
            ST_DONE: if (flush) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_en = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  acc_en = hit;
            ST_DONE: done   = 1'b1;
            default: ;
        endcase
    end

    assign cycle_count = cycle_q;

    loop_iter_domain #(.NDIM(NDIM), .EXT_W(EXT_W), .SEL_W(SEL_W)) u_iter (
        .clk(clk), .rst_n(rst_n), .load(flush), .step(step),
        .extent(ext_q), .sel(sel), .last(last)
    );

    affine_term_gen #(.NDIM(NDIM), .EXT_W(EXT_W), .VAL_W(ADDR_W), .SEL_W(SEL_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(flush), .step(step), .sel(sel),
        .offset(cfg_addr_off), .stride(astr_q), .extent(ext_q), .value(acc_addr)
    );

    affine_term_gen #(.NDIM(NDIM), .EXT_W(EXT_W), .VAL_W(TIME_W), .SEL_W(SEL_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .load(flush), .step(step), .sel(sel),
        .offset(cfg_sched_off), .stride(sstr_q), .extent(ext_q), .value(sched_val)
    );

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (cycle_count == $past(cycle_count) + TIME_W'(1)));
    a_r2_flush_restart: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cycle_count == '0 && !done));
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !acc_en && !flush) |=> $stable(acc_addr));
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flush) |=> done);
    a_r6_no_en_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !acc_en);
endmodule

// File: tb/sim_affine_loop_ctrl.sv
module sim_affine_loop_ctrl;
    localparam int NDIM = 6, EXT_W = 8, ADDR_W = 16, TIME_W = 16;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic [NDIM*EXT_W-1:0]  cfg_extent = '0;
    logic [ADDR_W-1:0]      cfg_addr_off = '0;
    logic [NDIM*ADDR_W-1:0] cfg_addr_stride = '0;
    logic [TIME_W-1:0]      cfg_sched_off = '0;
    logic [NDIM*TIME_W-1:0] cfg_sched_stride = '0;
    logic [TIME_W-1:0]      cycle_count;
    logic                   acc_en, done;
    logic [ADDR_W-1:0]      acc_addr;

    int checks = 0, errors = 0;
    int ext[NDIM], astr[NDIM], sstr[NDIM], aoff, soff;

    always #(CLK_PERIOD/2) clk = ~clk;

    affine_loop_ctrl #(.NDIM(NDIM), .EXT_W(EXT_W), .ADDR_W(ADDR_W), .TIME_W(TIME_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_extent(cfg_extent),
        .cfg_addr_off(cfg_addr_off), .cfg_addr_stride(cfg_addr_stride),
        .cfg_sched_off(cfg_sched_off), .cfg_sched_stride(cfg_sched_stride),
        .cycle_count(cycle_count), .acc_en(acc_en), .acc_addr(acc_addr), .done(done)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(int e[NDIM], int as[NDIM], int ss[NDIM], int ao, int so);
        for (int d = 0; d < NDIM; d++) begin
            ext[d] = e[d]; astr[d] = as[d]; sstr[d] = ss[d];
        end
        aoff = ao; soff = so;
    endtask

    task automatic drive_cfg();
        for (int d = 0; d < NDIM; d++) begin
            cfg_extent[d*EXT_W +: EXT_W]         = EXT_W'(ext[d]);
            cfg_addr_stride[d*ADDR_W +: ADDR_W]  = ADDR_W'(astr[d]);
            cfg_sched_stride[d*TIME_W +: TIME_W] = TIME_W'(sstr[d]);
        end
        cfg_addr_off  = ADDR_W'(aoff);
        cfg_sched_off = TIME_W'(soff);
    endtask

    // R9: garbage on the configuration ports after capture
    task automatic scramble_cfg();
        cfg_extent       = '1;
        cfg_addr_stride  = {NDIM{16'h1234}};
        cfg_sched_stride = {NDIM{16'h0001}};
        cfg_addr_off     = 16'hABCD;
        cfg_sched_off    = 16'h0000;
    endtask

    // pulse flush; returns at the negedge where cycle_count should be 0
    task automatic do_flush();
        @(negedge clk);
        drive_cfg();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        scramble_cfg();
    endtask

    // walk the loop nest against the outputs; stop_k < 0 means run to completion
    task automatic run_model(string tag, int stop_k);
        int idx[NDIM];
        int k, fin_k, a, s;
        bit fin, is_last, exp_en;
        for (int d = 0; d < NDIM; d++) idx[d] = 0;
        fin = 1'b0; fin_k = 0; k = 0;
        while (1) begin
            a = aoff; s = soff; is_last = 1'b1;
            for (int d = 0; d < NDIM; d++) begin
                a += astr[d] * idx[d];
                s += sstr[d] * idx[d];
                if (idx[d] != ext[d] - 1) is_last = 1'b0;
            end
            a &= 16'hFFFF; s &= 16'hFFFF;
            chk(cycle_count == TIME_W'(k), {tag, " R1"}, "cycle_count", int'(cycle_count), k);
            exp_en = !fin && (k == s);
            chk(acc_en == exp_en, {tag, " R5"}, "acc_en", int'(acc_en), int'(exp_en));
            if (!fin) chk(acc_addr == ADDR_W'(a), {tag, " R4"}, "acc_addr", int'(acc_addr), a);
            if (fin && k > fin_k) begin
                chk(done == 1'b1, {tag, " R6"}, "done", int'(done), 1);
            end else begin
                chk(done == 1'b0, {tag, " R6"}, "done early", int'(done), 0);
            end
            if (exp_en) begin
                if (is_last) begin
                    fin = 1'b1; fin_k = k;
                end else begin
                    idx[0]++;
                    for (int d = 0; d < NDIM - 1; d++) begin
                        if (idx[d] == ext[d]) begin idx[d] = 0; idx[d+1]++; end
                    end
                end
            end
            if (stop_k >= 0 && k >= stop_k) break;
            if (fin && k >= fin_k + 4) break;
            k++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(acc_en == 1'b0, "R7", "acc_en in reset", int'(acc_en), 0);
        chk(done == 1'b0, "R7", "done in reset", int'(done), 0);
        chk(cycle_count == '0, "R7", "cycle_count in reset", int'(cycle_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(cycle_count == TIME_W'(2), "R1", "idle counting", int'(cycle_count), 2);
        chk(acc_en == 1'b0 && done == 1'b0, "R7", "idle outputs", int'({acc_en, done}), 0);
    endtask

    task automatic t_two_level();   // R3 R4 R5 sparse schedule
        set_cfg('{4, 3, 1, 1, 1, 1}, '{1, 4, 0, 0, 0, 0}, '{2, 10, 0, 0, 0, 0}, 0, 1);
        do_flush(); run_model("two_level", -1);
    endtask

    task automatic t_three_level(); // R3 unequal extents, schedule from cycle 0
        set_cfg('{3, 2, 4, 1, 1, 1}, '{5, 1, 20, 0, 0, 0}, '{2, 7, 16, 0, 0, 0}, 100, 0);
        do_flush(); run_model("three_level", -1);
    endtask

    task automatic t_six_dense();   // R8 back-to-back, R4 address wrap
        set_cfg('{2, 2, 2, 2, 2, 2}, '{3, 7, 11, 13, 17, 100}, '{1, 2, 4, 8, 16, 32}, 16'hFFF0, 5);
        do_flush(); run_model("six_dense R8", -1);
    endtask

    task automatic t_single();      // R6 one iteration
        set_cfg('{1, 1, 1, 1, 1, 1}, '{9, 9, 9, 9, 9, 9}, '{9, 9, 9, 9, 9, 9}, 42, 3);
        do_flush(); run_model("single", -1);
    endtask

    task automatic t_flush_mid();   // R2 restart from RUN and from DONE
        set_cfg('{4, 3, 1, 1, 1, 1}, '{1, 4, 0, 0, 0, 0}, '{2, 10, 0, 0, 0, 0}, 0, 1);
        do_flush(); run_model("mid_run R2", 14);
        set_cfg('{2, 3, 1, 1, 1, 1}, '{2, 50, 0, 0, 0, 0}, '{3, 8, 0, 0, 0, 0}, 7, 2);
        do_flush(); run_model("after_flush R2 R9", -1);
        do_flush(); run_model("from_done R2", -1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_two_level();
        t_three_level();
        t_six_dense();
        t_single();
        t_flush_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule